// File: doc/BRIEF.md
# Limit-Compare Step Timer with Free-Running User Mode

This block is a memory-mapped counter/timer with a 32-bit word register port. An internal prescaler turns the input clock into one count step every `DIV` clock cycles, which is 500 ns when `DIV` equals the clock frequency times 500 ns. Each step adds 512 to the visible count, so the nine low bits of every count word read back are zero.

In system mode the count climbs toward a programmable bound. When it gets there it reloads to zero, latches a flag in bit 31 of the count word, and raises a level interrupt. Software acknowledges the interrupt by reading the bound register.

When `user_mode_i` is high, the same block becomes a 64-bit counter that software starts and stops. It reads the counter in two halves and never gets an interrupt from it. A change of the mode input restarts the block cleanly in the new mode.

Top module: `limit_step_timer`

## Requirements
- R1: After reset, the count is 0, the reached flag is 0, running is 1, `irq_o` is low, and the bound is the maximum for the mode then selected (0x7FFFFE00 in system mode, 0x7FFF_FFFF_FFFF_FE00 in user mode).
- R2: While running, the count rises by one step of 512 every `DIV` cycles. Bits 8:0 of any count word read back are zero.
- R3: In system mode, a write to word 0 (bound) has the following effects:
  - It stores the write data masked with 0x7FFFFE00, or 0x7FFFFE00 if the masked value is zero.
  - It restarts the count and the prescaler from zero.
  - It drops `irq_o` on the next edge but leaves the reached flag as it was.
  - It takes priority over a step in the same cycle.
- R4: A write to word 2 (soft bound) applies the same masking and zero substitution as R3 in system mode, but keeps the count and `irq_o`. In user mode this write is ignored.
- R5: A step that would bring the count to the bound or beyond instead reloads the count to zero. In system mode it also sets the reached flag and raises `irq_o`, both visible after that edge.
- R6: In system mode, a read of word 0 returns the bound (bit 31 zero) and clears the reached flag and `irq_o`. A wrap in the same cycle wins over that clear.
- R7: In system mode, a read of word 1 returns the count with bit 31 replaced by the reached flag. Writes to word 1 and word 3 are ignored in this mode.
- R8: In user mode, word 0 reads bits 63:32 of the 64-bit count, and word 1 reads bits 31:0 with bits 8:0 zero.
- R9: In user mode, a write to word 0 or word 1 sets the bound to 0x7FFF_FFFF_FFFF_FE00, restarts count and prescaler from zero, and keeps `irq_o` low. The data value does not matter.
- R10: In user mode, bit 0 of a write to word 3 starts the counter when 1 and stops it when 0. While stopped, count and prescaler hold. A read of word 3 returns the running flag in bit 0, with other bits zero.
- R11: `irq_o` is never high while the block is in user mode.
- R12: When `user_mode_i` differs from the registered mode, the next edge makes the following changes, overriding any access in that cycle:
  - count, reached flag and `irq_o` are cleared;
  - the bound is set to the new mode's maximum;
  - running is set to 1;
  - the prescaler is restarted.
- R13: The word index is `addr_i[4:2]`, and read data appears on `rdata_o` one cycle after `rd_en_i`. Word 4 reads the registered mode in bit 0. Word 2 and words 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| user_mode_i | input | 1 | 1 selects the free-running 64-bit user counter |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| rd_en_i | input | 1 | Read strobe for the addressed word |
| addr_i | input | 5 | Byte address; bits 4:2 select the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Level interrupt: the count wrapped at the bound in system mode |

## Verification
The properties assume that every input is settled at the sampling edge. They also assume at most one register access per cycle, so that no read side effect competes with a write, and that `user_mode_i` stays constant between deliberate changes.

The stimulus meets these conditions:
- Every strobe, address, data value and mode change is driven on the falling clock edge.
- Each access lasts exactly one cycle.
- A read and a write are never issued together.
- The mode input moves only while no access is in flight.

// File: rtl/limtmr_pkg.sv
package limtmr_pkg;
    parameter int unsigned WORD_W  = 32;
    parameter int unsigned FULL_W  = 64;
    parameter int unsigned UNIT_SH = 9;
    parameter int unsigned IDX_W   = 3;
    parameter int unsigned CNT_W   = FULL_W - UNIT_SH;
    parameter int unsigned SYS_W   = WORD_W - 1 - UNIT_SH;

    typedef logic [CNT_W-1:0] units_t;

    parameter units_t SYS_MAX_U = units_t'({SYS_W{1'b1}});
    parameter units_t USR_MAX_U = units_t'({(CNT_W-1){1'b1}});

    typedef enum logic [IDX_W-1:0] {
        IDX_BOUND = 3'd0,
        IDX_VALUE = 3'd1,
        IDX_SOFT  = 3'd2,
        IDX_RUN   = 3'd3,
        IDX_SEL   = 3'd4
    } reg_idx_e;

    typedef struct packed {
        units_t              cnt;
        units_t              lim;
        logic                reached;
        logic                irq;
        logic                running;
        logic                mode;
        logic [WORD_W-1:0]   rdata;
    } tmr_state_t;
endpackage

// File: rtl/limtmr_prescale.sv
module limtmr_prescale #(
    parameter int unsigned DIV = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_direct
            logic unused_direct;
            assign unused_direct = ^{clk_i, rst_ni, clr_i};
            assign tick_o = en_i;
        end else begin : g_count
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
            logic [PRE_W-1:0] pre_d, pre_q;

            assign tick_o = en_i && (pre_q == PRE_LAST);

            always_comb begin
                pre_d = pre_q;
                if (clr_i) begin
                    pre_d = '0;
                end else if (tick_o) begin
                    pre_d = '0;
                end else if (en_i) begin
                    pre_d = pre_q + 1'b1;
                end
            end

            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/limtmr_bound_decode.sv
module limtmr_bound_decode
    import limtmr_pkg::*;
(
    input  logic [SYS_W-1:0] field_i,
    output units_t           bound_o
);
    // A zero bound would never be reached in a useful way: substitute the maximum.
    assign bound_o = (field_i == '0) ? SYS_MAX_U : units_t'(field_i);
endmodule

// File: rtl/limtmr_rd_mux.sv
module limtmr_rd_mux
    import limtmr_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              user_i,
    input  logic              running_i,
    input  logic              reached_i,
    input  units_t            cnt_i,
    input  logic [SYS_W-1:0]  lim_lo_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int unsigned LO_W = WORD_W - UNIT_SH;

    always_comb begin
        word_o = '0;
        case (idx_i)
            IDX_BOUND: word_o = user_i ? cnt_i[CNT_W-1:LO_W]
                                       : {1'b0, lim_lo_i, {UNIT_SH{1'b0}}};
            IDX_VALUE: word_o = user_i ? {cnt_i[LO_W-1:0], {UNIT_SH{1'b0}}}
                                       : {reached_i, cnt_i[SYS_W-1:0], {UNIT_SH{1'b0}}};
            IDX_RUN:   word_o = {{(WORD_W-1){1'b0}}, running_i};
            IDX_SEL:   word_o = {{(WORD_W-1){1'b0}}, user_i};
            default:   word_o = '0;
        endcase
    end
endmodule

// File: rtl/limit_step_timer.sv
module limit_step_timer
    import limtmr_pkg::*;
#(
    parameter int unsigned DIV = 100
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 user_mode_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [IDX_W+1:0]     addr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [WORD_W-1:0]    rdata_o,
    output logic                 irq_o
);
    tmr_state_t st_d, st_q, st_rst;

    logic [IDX_W-1:0]  idx;
    logic              mode_flip;
    logic              restart;
    logic              tick;
    logic              wrap_hit;
    units_t            cnt_inc;
    units_t            wr_bound;
    logic [WORD_W-1:0] rd_word;
    logic              unused_bits;

    assign idx         = addr_i[IDX_W+1:2];
    assign unused_bits = ^{addr_i[1:0], wdata_i[WORD_W-1], wdata_i[UNIT_SH-1:1]};
    assign mode_flip   = (user_mode_i != st_q.mode);

    // Count and prescaler restart on a mode change, a system bound write,
    // or any user write to words 0/1.
    assign restart = mode_flip ||
                     (wr_en_i && (idx == IDX_BOUND)) ||
                     (wr_en_i && st_q.mode && (idx == IDX_VALUE));

    limtmr_prescale #(.DIV(DIV)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (st_q.running),
        .clr_i  (restart),
        .tick_o (tick)
    );

    limtmr_bound_decode u_dec (
        .field_i (wdata_i[WORD_W-2:UNIT_SH]),
        .bound_o (wr_bound)
    );

    limtmr_rd_mux u_mux (
        .idx_i     (idx),
        .user_i    (st_q.mode),
        .running_i (st_q.running),
        .reached_i (st_q.reached),
        .cnt_i     (st_q.cnt),
        .lim_lo_i  (st_q.lim[SYS_W-1:0]),
        .word_o    (rd_word)
    );

    assign cnt_inc  = st_q.cnt + 1'b1;
    assign wrap_hit = tick && (cnt_inc >= st_q.lim);

    always_comb begin
        st_rst         = '0;
        st_rst.lim     = user_mode_i ? USR_MAX_U : SYS_MAX_U;
        st_rst.running = 1'b1;
        st_rst.mode    = user_mode_i;
    end

    always_comb begin
        st_d = st_q;

        if (rd_en_i) begin
            st_d.rdata = rd_word;
        end

        // Acknowledge by reading the bound (system mode only).
        if (rd_en_i && (idx == IDX_BOUND) && !st_q.mode) begin
            st_d.reached = 1'b0;
            st_d.irq     = 1'b0;
        end

        // Step; a wrap sets the flag after the acknowledge so the event is not lost.
        if (tick) begin
            if (wrap_hit) begin
                st_d.cnt = '0;
                if (!st_q.mode) begin
                    st_d.reached = 1'b1;
                    st_d.irq     = 1'b1;
                end
            end else begin
                st_d.cnt = cnt_inc;
            end
        end

        if (wr_en_i) begin
            case (idx)
                IDX_BOUND: begin
                    st_d.lim = st_q.mode ? USR_MAX_U : wr_bound;
                    st_d.cnt = '0;
                    st_d.irq = 1'b0;
                end
                IDX_VALUE: begin
                    if (st_q.mode) begin
                        st_d.lim = USR_MAX_U;
                        st_d.cnt = '0;
                        st_d.irq = 1'b0;
                    end
                end
                IDX_SOFT: begin
                    if (!st_q.mode) begin
                        st_d.lim = wr_bound;
                    end
                end
                IDX_RUN: begin
                    if (st_q.mode) begin
                        st_d.running = wdata_i[0];
                    end
                end
                default: ;
            endcase
        end

        if (mode_flip) begin
            st_d.mode    = user_mode_i;
            st_d.lim     = user_mode_i ? USR_MAX_U : SYS_MAX_U;
            st_d.cnt     = '0;
            st_d.running = 1'b1;
            st_d.reached = 1'b0;
            st_d.irq     = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/limtmr_checks.sv
module limtmr_checks
    import limtmr_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              user_mode_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [IDX_W-1:0]  idx,
    input logic [WORD_W-1:0] rdata_o,
    input logic              irq_o,
    input logic              mode_q,
    input logic              running_q,
    input units_t            cnt_q,
    input logic              tick,
    input logic              wrap_hit
);
    logic quiet;
    assign quiet = (user_mode_i == mode_q) && !wr_en_i;

    assert_no_irq_user_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_q |-> !irq_o);

    // Also covers R9: user bound writes reset the count and keep the interrupt low.
    assert_bound_wr_resets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && idx == IDX_BOUND) |=> (!irq_o && cnt_q == '0));

    assert_bound_rd_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && idx == IDX_BOUND && !mode_q && !wrap_hit) |=> !irq_o);

    assert_soft_keeps_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && idx == IDX_SOFT && !tick && user_mode_i == mode_q) |=> $stable(cnt_q));

    assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet && tick && !wrap_hit) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_cnt_low_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && idx == IDX_VALUE) |=> (rdata_o[UNIT_SH-1:0] == '0));

    assert_run_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && idx == IDX_RUN) |=> (rdata_o[WORD_W-1:1] == '0 && rdata_o[0] == $past(running_q)));

    assert_stopped_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet && !running_q) |=> $stable(cnt_q));

    assert_mode_flip_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_mode_i != mode_q) |=> (cnt_q == '0 && running_q && !irq_o));
endmodule

bind limit_step_timer limtmr_checks u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .user_mode_i (user_mode_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .idx         (idx),
    .rdata_o     (rdata_o),
    .irq_o       (irq_o),
    .mode_q      (st_q.mode),
    .running_q   (st_q.running),
    .cnt_q       (st_q.cnt),
    .tick        (tick),
    .wrap_hit    (wrap_hit)
);

// File: tb/limit_step_timer_tb_top.sv
`timescale 1ns/1ps
module limit_step_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen;

    localparam logic [2:0] W_BOUND = 3'd0;
    localparam logic [2:0] W_VALUE = 3'd1;
    localparam logic [2:0] W_SOFT  = 3'd2;
    localparam logic [2:0] W_RUN   = 3'd3;
    localparam logic [2:0] W_SEL   = 3'd4;

    always #2.5 clk = ~clk;

    limit_step_timer #(.DIV(4)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .user_mode_i (user),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .irq_o       (irq)
    );

    // Monitor: a read strobed at one edge is compared at the next falling edge.
    always @(posedge clk) rd_seen <= rst_n && rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read result %h with no expected item", rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] i, input logic [31:0] d);
        wr_en = 1'b1; addr = {i, 2'b00}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] i, input logic [31:0] e, input string t);
        rd_en = 1'b1; addr = {i, 2'b00};
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq=%b expected %b", t, irq, e);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(W_VALUE, 32'h0000_0000, "R1 count after reset");
        rd(W_BOUND, 32'h7FFF_FE00, "R1 bound after reset");
        rd(W_RUN,   32'h0000_0001, "R1 running after reset");
        rd(W_SEL,   32'h0000_0000, "R13 mode word in system mode");

        // R2: stepping by 512 every 4 cycles
        wr(W_BOUND, 32'h7FFF_FE00);
        gap(9);
        rd(W_VALUE, 32'h0000_0400, "R2 two steps");
        rd(W_VALUE, 32'h0000_0400, "R2 held between steps");
        gap(1);
        rd(W_VALUE, 32'h0000_0600, "R2 third step");

        // R3: zero bound becomes maximum
        wr(W_BOUND, 32'h0000_01FF);
        rd(W_BOUND, 32'h7FFF_FE00, "R3 zero bound substituted");

        // R5/R6/R7: wrap at a 6-step bound, acknowledge by bound read
        wr(W_BOUND, 32'h8000_0DFF);
        gap(23);
        chk_irq(1'b0, "R5 irq before wrap");
        gap(1);
        chk_irq(1'b1, "R5 irq at wrap");
        rd(W_VALUE, 32'h8000_0000, "R7 reached flag with reloaded count");
        rd(W_BOUND, 32'h0000_0C00, "R6 masked bound read");
        chk_irq(1'b0, "R6 irq cleared by bound read");
        rd(W_VALUE, 32'h0000_0000, "R6 reached flag cleared");

        // R4: soft bound keeps the running count
        wr(W_BOUND, 32'h7FFF_FE00);
        gap(9);
        wr(W_SOFT, 32'h0000_1000);
        rd(W_VALUE, 32'h0000_0400, "R4 count kept by soft bound");
        gap(20);
        chk_irq(1'b0, "R4 no wrap before soft bound");
        gap(1);
        chk_irq(1'b1, "R4 wrap at soft bound");
        wr(W_VALUE, 32'h5555_5555);
        chk_irq(1'b1, "R7 count write ignored in system mode");
        wr(W_RUN, 32'h0000_0000);
        wr(W_BOUND, 32'h7FFF_FE00);
        chk_irq(1'b0, "R3 bound write drops irq");
        rd(W_VALUE, 32'h8000_0000, "R3 reached kept, count restarted");
        rd(W_RUN,   32'h0000_0001, "R7 run write ignored in system mode");
        rd(W_BOUND, 32'h7FFF_FE00, "R6 bound read");
        rd(W_VALUE, 32'h0000_0000, "R6 reached cleared");

        // R13: unused words; R4 zero soft bound
        rd(W_SOFT, 32'h0000_0000, "R13 soft word reads zero");
        rd(3'd5,   32'h0000_0000, "R13 word 5 reads zero");
        wr(W_SOFT, 32'h0000_0000);
        rd(W_BOUND, 32'h7FFF_FE00, "R4 zero soft bound substituted");

        // R12: mode change clears a pending interrupt
        wr(W_BOUND, 32'h0000_0200);
        gap(3);
        chk_irq(1'b0, "R5 one-step bound before wrap");
        gap(1);
        chk_irq(1'b1, "R5 one-step bound wrap");
        user = 1'b1;
        gap(1);
        chk_irq(1'b0, "R12 irq cleared on mode change");

        // R8/R10: user counter, stop and start
        gap(7);
        wr(W_RUN, 32'h0000_0000);
        rd(W_VALUE, 32'h0000_0400, "R8 user low word");
        rd(W_BOUND, 32'h0000_0000, "R8 user high word");
        rd(W_RUN,   32'h0000_0000, "R10 stopped flag");
        rd(W_SEL,   32'h0000_0001, "R13 mode word in user mode");
        gap(8);
        rd(W_VALUE, 32'h0000_0400, "R10 count holds while stopped");
        wr(W_RUN, 32'h0000_0001);
        gap(3);
        rd(W_VALUE, 32'h0000_0400, "R10 first step after start not yet");
        rd(W_VALUE, 32'h0000_0600, "R10 step after start");
        chk_irq(1'b0, "R11 no irq in user mode");

        // R9 and R4 in user mode
        wr(W_VALUE, 32'hDEAD_BEEF);
        wr(W_SOFT, 32'h0000_1000);
        gap(38);
        rd(W_VALUE, 32'h0000_1200, "R4 soft bound ignored in user mode");
        wr(W_BOUND, 32'hFFFF_FFFF);
        rd(W_VALUE, 32'h0000_0000, "R9 user bound write resets count");
        rd(W_BOUND, 32'h0000_0000, "R9 high word after reset");
        chk_irq(1'b0, "R11 irq low after user writes");

        // R12: back to system mode restarts
        wr(W_RUN, 32'h0000_0000);
        user = 1'b0;
        gap(1);
        rd(W_BOUND, 32'h7FFF_FE00, "R12 system bound restored");
        rd(W_RUN,   32'h0000_0001, "R12 running after mode change");
        rd(W_VALUE, 32'h0000_0000, "R12 count zero after mode change");

        gap(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d reads never returned, expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run still active=1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule